// File: doc/BRIEF.md
# Magnetometer Register Pointer Sequencer

This block is the second I2C target on an SCL/SDA pair that the accelerometer bank also uses. It answers only at its own 7-bit address, takes the first data byte of a write as a register pointer, and then steps that pointer after every data byte it reads or writes. The step does not simply count up. From 8 it jumps back to 3, and from 12 or above it wraps to 0. A master can therefore sweep the data and status registers again and again without sending the pointer each time.

The register file behind the pointer is a stub. Every read byte is 0x00, and written data is dropped; only the pointer moves. The current pointer is brought out as the address toward the register file. The block drives SDA through an active-low open-drain enable. That enable is ANDed with the other target's enable to form the single SDA pin drive, so either target can pull the line low. SCL and SDA are sampled on the system clock and pass through a synchronizer before edge and START/STOP detection.

Top module: `mag_ptr_target`

## Requirements
- R1: An address byte whose upper seven bits are 0x1E (0x3C for a write, 0x3D for a read) is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R2: When the block is in the pointer-load phase, the first data byte written after an address match is copied whole into `reg_addr_o`, and the block leaves that phase.
- R3: Outside the load phase, each data byte transferred (read or written) steps the pointer: a value of 8 becomes 3, a value of 12 or more becomes 0, and any other value goes up by 1. With no byte transferred and no STOP, the pointer holds.
- R4: A STOP condition puts the block back in the pointer-load phase, so the next written byte loads the pointer again.
- R5: Each read data bit is driven low, so every byte read is 0x00. Written data changes nothing except the pointer.
- R6: `sda_o` is the AND of the block's own active-low enable and `peer_sda_i`. While the block is idle, its own enable is released (high).
- R7: After reset, `reg_addr_o` is 0, SDA is released, and the block is in the pointer-load phase.
- R8: Every data byte written to the matched address is acknowledged.
- R9: After the master NACKs a read byte, the block releases SDA and stops driving until the next START.
- R10: A repeated START without a STOP keeps the block out of the load phase, so the first byte of the new write steps the pointer instead of loading it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| peer_sda_i | input | 1 | Other target's active-low SDA enable (0 pulls the line low) |
| sda_o | output | 1 | Combined active-low SDA enable for the pad (0 pulls the line low) |
| reg_addr_o | output | 8 | Current register pointer toward the register file |

## Verification
The assertions assume that the bus is slow compared with the system clock. SDA changes only while SCL has been low for at least two clocks, except on START and STOP, and each SCL level lasts longer than the synchronizer and edge-detect latency. The bench's master tasks keep every SCL phase at eight clocks and move SDA two clocks after each SCL fall. Random stimulus covers matching and foreign addresses, read and write directions, burst lengths of one to four bytes, pointer seeds in and outside the sequence range, and STOP versus repeated START. All of it is generated through those same timing-safe tasks.

// File: rtl/mag_ptr_pkg.sv
package mag_ptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  localparam logic [6:0] MAG_ADDR7 = 7'h1E;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic         scl_d, sda_d;
  logic         scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[MSB-1:0], scl_i};
      sda_sh <= {sda_sh[MSB-1:0], sda_i};
      scl_d  <= scl_sh[MSB];
      sda_d  <= sda_sh[MSB];
    end
  end

  assign scl_s      = scl_sh[MSB];
  assign sda_s      = sda_sh[MSB];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA edges count as START/STOP only while SCL has been high for two samples.
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import mag_ptr_pkg::*;
#(
  parameter logic [6:0] ADDR7  = MAG_ADDR7,
  parameter int         BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sda_n_o,
  output logic              wr_byte_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_byte_o
);
  localparam int               CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  bits_q;
  logic [BYTE_W-1:0] shift_q, tx_q;
  logic              rw_q, nack_q, sda_n_q;
  logic              byte_full, addr_hit;

  assign byte_full = (bits_q == FULL);
  assign addr_hit  = (shift_q[BYTE_W-1:1] == ADDR7);
  assign wr_byte_o = scl_fall_i && (state_q == ST_WR) && byte_full;
  assign rd_byte_o = scl_fall_i && (state_q == ST_RD) && byte_full;
  assign wr_data_o = shift_q;
  assign sda_n_o   = sda_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      sda_n_q <= 1'b1;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      bits_q  <= '0;
      sda_n_q <= 1'b1;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      sda_n_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i) begin
            shift_q <= {shift_q[BYTE_W-2:0], sda_i};
            bits_q  <= bits_q + 1'b1;
          end else if (scl_fall_i && byte_full) begin
            if (state_q == ST_WR) begin
              state_q <= ST_WR_ACK;
              sda_n_q <= 1'b0;
            end else if (addr_hit) begin
              state_q <= ST_ADDR_ACK;
              sda_n_q <= 1'b0;
              rw_q    <= shift_q[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (scl_fall_i) begin
            bits_q <= '0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_q <= ST_RD;
              sda_n_q <= tx_byte_i[BYTE_W-1];
              tx_q    <= {tx_byte_i[BYTE_W-2:0], 1'b0};
            end else begin
              state_q <= ST_WR;
              sda_n_q <= 1'b1;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bits_q <= bits_q + 1'b1;
          end else if (scl_fall_i) begin
            if (byte_full) begin
              state_q <= ST_RD_ACK;
              sda_n_q <= 1'b1;
            end else begin
              sda_n_q <= tx_q[BYTE_W-1];
              tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            nack_q <= sda_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_RD;
              bits_q  <= '0;
              sda_n_q <= tx_byte_i[BYTE_W-1];
              tx_q    <= {tx_byte_i[BYTE_W-2:0], 1'b0};
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_idle_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> sda_n_o);

  p_addr_ack_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && scl_fall_i && byte_full && addr_hit) |=> !sda_n_o);

  p_wr_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_byte_o |=> !sda_n_o);

  p_nack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK) |-> sda_n_o);

  p_one_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_byte_o, rd_byte_o, start_i, stop_i}));

endmodule

// File: rtl/mag_ptr_seq.sv
module mag_ptr_seq #(
  parameter int PTR_W     = 8,
  parameter int JUMP_FROM = 8,
  parameter int JUMP_TO   = 3,
  parameter int WRAP_AT   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_byte_i,
  input  logic [PTR_W-1:0] wr_data_i,
  input  logic             rd_byte_i,
  input  logic             stop_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] FROM_V = PTR_W'(JUMP_FROM);
  localparam logic [PTR_W-1:0] TO_V   = PTR_W'(JUMP_TO);
  localparam logic [PTR_W-1:0] WRAP_V = PTR_W'(WRAP_AT);

  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic             load_q, adv;

  assign adv = wr_byte_i | rd_byte_i;

  always_comb begin
    if (ptr_q == FROM_V)      ptr_nxt = TO_V;
    else if (ptr_q >= WRAP_V) ptr_nxt = '0;
    else                      ptr_nxt = ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      load_q <= 1'b1;
    end else if (stop_i) begin
      load_q <= 1'b1;
    end else if (wr_byte_i && load_q) begin
      ptr_q  <= wr_data_i;
      load_q <= 1'b0;
    end else if (adv) begin
      ptr_q <= ptr_nxt;
    end
  end

  assign ptr_o = ptr_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_byte_i && load_q) |=> (ptr_q == $past(wr_data_i)) && !load_q);

  p_jump_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !load_q && ptr_q == FROM_V) |=> ptr_q == TO_V);

  p_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !load_q) |=> ptr_q <= WRAP_V);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(ptr_q));

  p_stop_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> load_q);

endmodule

// File: rtl/mag_ptr_target.sv
module mag_ptr_target
  import mag_ptr_pkg::*;
#(
  parameter logic [6:0] ADDR7       = MAG_ADDR7,
  parameter int         BYTE_W      = 8,
  parameter int         JUMP_FROM   = 8,
  parameter int         JUMP_TO     = 3,
  parameter int         WRAP_AT     = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              peer_sda_i,
  output logic              sda_o,
  output logic [BYTE_W-1:0] reg_addr_o
);
  localparam logic [BYTE_W-1:0] STUB_RD = '0;

  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              own_sda_n, wr_byte, rd_byte;
  logic [BYTE_W-1:0] wr_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_tgt_fsm #(.ADDR7(ADDR7), .BYTE_W(BYTE_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .tx_byte_i  (STUB_RD),
    .sda_n_o    (own_sda_n),
    .wr_byte_o  (wr_byte),
    .wr_data_o  (wr_data),
    .rd_byte_o  (rd_byte)
  );

  mag_ptr_seq #(
    .PTR_W     (BYTE_W),
    .JUMP_FROM (JUMP_FROM),
    .JUMP_TO   (JUMP_TO),
    .WRAP_AT   (WRAP_AT)
  ) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_byte_i (wr_byte),
    .wr_data_i (wr_data),
    .rd_byte_i (rd_byte),
    .stop_i    (stop_ev),
    .ptr_o     (reg_addr_o)
  );

  // Wired-AND of two active-low pull-down enables.
  assign sda_o = own_sda_n & peer_sda_i;

  p_peer_pull_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peer_sda_i |-> !sda_o);

endmodule

// File: tb/mag_ptr_target_bench.sv
module mag_ptr_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       peer = 1'b1;
  logic       sda_o;
  logic       sda_line;
  logic [7:0] reg_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_ptr = 0;
  bit exp_load = 1'b1;

  assign sda_line = m_sda & sda_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mag_ptr_target u_mag_ptr_target (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .peer_sda_i (peer),
    .sda_o      (sda_o),
    .reg_addr_o (reg_addr)
  );

  function automatic int nxt(input int p);
    if (p == 8) return 3;
    if (p >= 12) return 0;
    return p + 1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    scl = 1'b0; tick(H);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(H);
    scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
    exp_load = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      scl = 1'b1; tick(H);
      scl = 1'b0; tick(2);
    end
    m_sda = 1'b1; tick(H);
    scl = 1'b1; tick(H / 2);
    acked = (sda_line == 1'b0);
    tick(H / 2);
    scl = 1'b0; tick(H);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      scl = 1'b1; tick(H / 2);
      b[i] = sda_line;
      tick(H / 2);
      scl = 1'b0; tick(2);
    end
    m_sda = nack; tick(H);
    scl = 1'b1; tick(H);
    scl = 1'b0; tick(H);
  endtask

  // Write one data byte to an addressed target and track the pointer model.
  task automatic wr_data(input logic [7:0] b);
    bit ack;
    send_byte(b, ack);
    chk(ack, "R8 data ack", ack, 1);
    if (exp_load) begin
      exp_ptr = b;
      exp_load = 1'b0;
      chk(reg_addr == 8'(exp_ptr), "R2 pointer load", reg_addr, exp_ptr);
    end else begin
      exp_ptr = nxt(exp_ptr);
      chk(reg_addr == 8'(exp_ptr), "R3 pointer step on write", reg_addr, exp_ptr);
    end
  endtask

  task automatic rd_data(input bit nack);
    logic [7:0] d;
    recv_byte(nack, d);
    chk(d == 8'h00, "R5 read data zero", d, 0);
    exp_ptr = nxt(exp_ptr);
    chk(reg_addr == 8'(exp_ptr), "R3 pointer step on read", reg_addr, exp_ptr);
    if (nack) chk(sda_o == 1'b1, "R9 release after nack", sda_o, 1);
  endtask

  task automatic addr_phase(input logic [6:0] a7, input bit rw);
    bit ack;
    send_byte({a7, rw}, ack);
    chk(ack == (a7 == 7'h1E), "R1 address decode", ack, (a7 == 7'h1E));
  endtask

  initial begin
    int n;
    logic [6:0] a7;
    bit rw;
    bit ack;
    void'($urandom(32'h5eed_1e3c));
    tick(4);
    chk(reg_addr == 8'h00, "R7 reset pointer", reg_addr, 0);
    chk(sda_o == 1'b1, "R7 reset release", sda_o, 1);
    rst_n = 1'b1;
    tick(4);

    // Directed: load then run through the jump at 8.
    bus_start(); addr_phase(7'h1E, 1'b0);
    wr_data(8'd7);
    for (int k = 0; k < 6; k++) wr_data(8'($urandom));
    bus_stop();
    chk(reg_addr == 8'd7, "R3 sequence 7,8,3..7", reg_addr, 7);

    // Wrap from 11 and from a value above the range.
    bus_start(); addr_phase(7'h1E, 1'b0);
    wr_data(8'd11); wr_data(8'hAA); wr_data(8'h55);
    bus_stop();
    chk(reg_addr == 8'd0, "R3 wrap at 12", reg_addr, 0);
    bus_start(); addr_phase(7'h1E, 1'b0);
    wr_data(8'hFF); wr_data(8'h00);
    bus_stop();

    // STOP reloads; repeated START does not.
    bus_start(); addr_phase(7'h1E, 1'b0);
    wr_data(8'd5);
    bus_rstart(); addr_phase(7'h1E, 1'b0);
    wr_data(8'd9);
    chk(reg_addr == 8'd6, "R10 no reload after repeated start", reg_addr, 6);
    bus_stop();
    bus_start(); addr_phase(7'h1E, 1'b0);
    wr_data(8'd2);
    chk(reg_addr == 8'd2, "R4 reload after stop", reg_addr, 2);

    // Reads after writes still return zero; nack releases.
    bus_rstart(); addr_phase(7'h1E, 1'b1);
    rd_data(1'b0); rd_data(1'b0); rd_data(1'b1);
    bus_stop();

    // Foreign address ignored.
    bus_start(); addr_phase(7'h19, 1'b0);
    send_byte(8'h0B, ack);
    chk(!ack, "R1 foreign data not acked", ack, 0);
    bus_stop();
    chk(reg_addr == 8'(exp_ptr), "R1 foreign transfer leaves pointer", reg_addr, exp_ptr);

    // Peer pull-down and idle release.
    peer = 1'b0; tick(2);
    chk(sda_o == 1'b0, "R6 peer pulls line", sda_o, 0);
    peer = 1'b1; tick(2);
    chk(sda_o == 1'b1, "R6 idle release", sda_o, 1);

    // Constrained random transfers.
    for (int t = 0; t < 40; t++) begin
      a7 = ($urandom % 4 != 0) ? 7'h1E : 7'($urandom % 30);
      rw = 1'($urandom);
      n  = 1 + $urandom % 4;
      bus_start(); addr_phase(a7, rw);
      if (a7 != 7'h1E) begin
        send_byte(8'($urandom), ack);
        chk(!ack, "R1 ignored after foreign address", ack, 0);
      end else if (rw) begin
        for (int k = 0; k < n; k++) rd_data(k == n - 1);
      end else begin
        for (int k = 0; k < n; k++)
          wr_data(($urandom % 2) ? 8'($urandom % 16) : 8'($urandom));
      end
      if (!rw && a7 == 7'h1E && $urandom % 4 == 0) begin
        bus_rstart(); addr_phase(7'h1E, 1'b0);
        wr_data(8'($urandom));
      end
      bus_stop();
      chk(reg_addr == 8'(exp_ptr), "R3 pointer after transfer", reg_addr, exp_ptr);
      chk(sda_o == 1'b1, "R6 released when idle", sda_o, 1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule